// File: doc/BRIEF.md
# Display Link Bring-Up Sequencer

This block controls the transmit side of a display bridge. Software reaches it through a small register port with an 8-bit address and 8-bit data. Through that port it turns on the link PLL and requests link training. Once training has passed, it turns on the video stream. Shutdown runs the same steps in reverse.

The analog PLL and the physical training engine sit outside the block. They appear only as a lock input and as a done/pass pair. All three inputs are asynchronous and are resynchronised inside the block.

The hardware enforces the bring-up and shutdown ordering. A write that would break the ordering is dropped. A training attempt always reaches a final result code within a bounded number of cycles, so a polling host never waits on it forever.

Top module: `link_bringup_seq`

## Requirements
- R1: After synchronous reset every register reads 0x00 and every output is 0.
- R2: Writing a value with bit 0 set to the PLL control register (address 0x0D) raises `pll_en_o` on the next clock. That register reads back `pll_en_o` in bit 0.
- R3: The clock configuration register (address 0x0A) stores written bits 3:0. Bit 0 drives `clk_src_dsi_o` and bits 3:1 drive `ref_idx_o`. Bits 6:4 read 0 and ignore writes. Bit 7 reads the lock flag: `pll_lock_i` after a two-stage synchroniser, ANDed with the PLL enable. A change on `pll_lock_i` shows in bit 7 two clocks later and not one.
- R4: Writing 0x0A to the link mode register (address 0x96) while locked starts training. The register then reads 0x0A, `train_req_o` is 1 and `link_state_o` is 1. Two clocks after `train_done_i` rises, the register still reads 0x0A. One clock after that it reads 0x01 if `train_pass_i` was 1 (`link_state_o`=2), or 0x00 if it was 0 (`link_state_o`=0).
- R5: A training request made while not locked reads 0x00 on the next clock, and `train_req_o` stays 0.
- R6: If no done arrives, training ends as a failure (0x00) after exactly TRAIN_TIMEOUT clocks. The register still reads 0x0A in the clock before that.
- R7: Bit 3 of the stream register (address 0x5A) drives `stream_en_o`. A write to it takes effect only while `link_state_o` is 2; otherwise the bit stays 0. All other bits of the register read 0.
- R8: Writes to the link mode register (0x00 or 0x0A) are ignored while the stream is on. Writing 0 to the PLL control register is ignored unless `link_state_o` is 0.
- R9: When the lock flag drops during training or normal mode, the link returns to off. A running stream is cleared on the same clock.
- R10: Writes to the link mode register of any value other than 0x00 or 0x0A have no effect.
- R11: `reg_rdata_o` is combinational from the current state while `reg_rd_i` is 1. It is 0x00 when `reg_rd_i` is 0 or the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, same cycle as strobe |
| pll_lock_i | input | 1 | Asynchronous PLL lock indication |
| train_done_i | input | 1 | Asynchronous training-finished indication |
| train_pass_i | input | 1 | Training result, valid with done |
| pll_en_o | output | 1 | PLL enable |
| clk_src_dsi_o | output | 1 | PLL source select |
| ref_idx_o | output | 3 | Reference frequency index |
| train_req_o | output | 1 | Training in progress |
| link_state_o | output | 2 | 0 off, 1 training, 2 normal |
| stream_en_o | output | 1 | Video stream enable |
| lock_o | output | 1 | Synchronised lock gated by PLL enable |

## Verification
Two situations are hard to reach from the ports. The first is the exact cycle on which a training attempt with no response gives up. The bench starts training with done held low, counts clocks from the accepted write, and reads the mode register in the two clocks on either side of the limit. The second is losing lock while the stream runs. The bench first completes a passing training and enables the stream. It then drops the lock input and checks on each clock through the synchroniser that link state and stream enable both stay up until the same clock, and then fall together.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;

  typedef enum logic [1:0] {
    LINK_OFF    = 2'd0,
    LINK_TRAIN  = 2'd1,
    LINK_NORMAL = 2'd2
  } link_state_e;

  localparam logic [7:0] CODE_OFF    = 8'h00;
  localparam logic [7:0] CODE_NORMAL = 8'h01;
  localparam logic [7:0] CODE_TRAIN  = 8'h0A;

  function automatic logic [7:0] state_code(input link_state_e st);
    case (st)
      LINK_TRAIN:  state_code = CODE_TRAIN;
      LINK_NORMAL: state_code = CODE_NORMAL;
      default:     state_code = CODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/lbs_sync.sv
`timescale 1ns/1ps
module lbs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[DEPTH-2:0], async_i};
  end

  assign sync_o = chain_q[DEPTH-1];

endmodule

// File: rtl/lbs_train_ctrl.sv
`timescale 1ns/1ps
module lbs_train_ctrl
  import lbs_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        cancel_i,
  input  logic        locked_i,
  input  logic        done_i,
  input  logic        pass_i,
  output link_state_e state_o,
  output link_state_e state_nxt_o
);

  localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  link_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      state_d = locked_i ? LINK_TRAIN : LINK_OFF;
      cnt_d   = '0;
    end else if (cancel_i) begin
      state_d = LINK_OFF;
    end else begin
      case (state_q)
        LINK_TRAIN: begin
          if (!locked_i)        state_d = LINK_OFF;
          else if (done_i)      state_d = pass_i ? LINK_NORMAL : LINK_OFF;
          else if (cnt_q == LAST) state_d = LINK_OFF;
          else                  cnt_d = cnt_q + 1'b1;
        end
        LINK_NORMAL: if (!locked_i) state_d = LINK_OFF;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LINK_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_d;

endmodule

// File: rtl/lbs_read_mux.sv
`timescale 1ns/1ps
module lbs_read_mux
  import lbs_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  ADDR_PLL   = 8'h0D,
  parameter logic [7:0]  ADDR_CLK   = 8'h0A,
  parameter logic [7:0]  ADDR_MODE  = 8'h96,
  parameter logic [7:0]  ADDR_FRAME = 8'h5A,
  parameter int          CFG_W      = 4,
  parameter int          LOCK_BIT   = 7,
  parameter int          STREAM_BIT = 3
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pll_en_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              lock_i,
  input  link_state_e       state_i,
  input  logic              stream_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        ADDR_W'(ADDR_PLL):   rdata_o[0] = pll_en_i;
        ADDR_W'(ADDR_CLK): begin
          rdata_o[CFG_W-1:0] = cfg_i;
          rdata_o[LOCK_BIT]  = lock_i;
        end
        ADDR_W'(ADDR_MODE):  rdata_o = DATA_W'(state_code(state_i));
        ADDR_W'(ADDR_FRAME): rdata_o[STREAM_BIT] = stream_i;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/link_bringup_seq.sv
`timescale 1ns/1ps
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int         ADDR_W        = 8,
  parameter int         DATA_W        = 8,
  parameter logic [7:0] ADDR_PLL      = 8'h0D,
  parameter logic [7:0] ADDR_CLK      = 8'h0A,
  parameter logic [7:0] ADDR_MODE     = 8'h96,
  parameter logic [7:0] ADDR_FRAME    = 8'h5A,
  parameter int         REF_IDX_W     = 3,
  parameter int         SYNC_STAGES   = 2,
  parameter int         TRAIN_TIMEOUT = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic                 pll_lock_i,
  input  logic                 train_done_i,
  input  logic                 train_pass_i,
  output logic                 pll_en_o,
  output logic                 clk_src_dsi_o,
  output logic [REF_IDX_W-1:0] ref_idx_o,
  output logic                 train_req_o,
  output logic [1:0]           link_state_o,
  output logic                 stream_en_o,
  output logic                 lock_o
);

  localparam int CFG_W      = REF_IDX_W + 1;
  localparam int LOCK_BIT   = DATA_W - 1;
  localparam int STREAM_BIT = 3;
  localparam int N_SYNC     = 3;

  // write decode
  logic wr_pll, wr_clk, wr_mode, wr_frame;
  assign wr_pll   = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_PLL));
  assign wr_clk   = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CLK));
  assign wr_mode  = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_MODE));
  assign wr_frame = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_FRAME));

  // input synchronisers
  logic [N_SYNC-1:0] sync_w;
  logic lock_s, done_s, pass_s;

  lbs_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({train_pass_i, train_done_i, pll_lock_i}),
    .sync_o  (sync_w)
  );
  assign {pass_s, done_s, lock_s} = sync_w;

  // configuration and enable registers
  logic             pll_en_q;
  logic [CFG_W-1:0] cfg_q;
  logic             stream_q;
  logic             locked;
  link_state_e      state, state_nxt;

  assign locked = lock_s && pll_en_q;

  logic start_req, cancel_req;
  assign start_req  = wr_mode && !stream_q && (reg_wdata_i == DATA_W'(CODE_TRAIN));
  assign cancel_req = wr_mode && !stream_q && (reg_wdata_i == DATA_W'(CODE_OFF));

  lbs_train_ctrl #(.TIMEOUT(TRAIN_TIMEOUT)) u_train (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_req),
    .cancel_i    (cancel_req),
    .locked_i    (locked),
    .done_i      (done_s),
    .pass_i      (pass_s),
    .state_o     (state),
    .state_nxt_o (state_nxt)
  );

  logic stream_d;
  always_comb begin
    stream_d = wr_frame ? reg_wdata_i[STREAM_BIT] : stream_q;
    if (state_nxt != LINK_NORMAL) stream_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_en_q <= 1'b0;
      cfg_q    <= '0;
      stream_q <= 1'b0;
    end else begin
      if (wr_pll) begin
        if (reg_wdata_i[0])         pll_en_q <= 1'b1;
        else if (state == LINK_OFF) pll_en_q <= 1'b0;
      end
      if (wr_clk) cfg_q <= reg_wdata_i[CFG_W-1:0];
      stream_q <= stream_d;
    end
  end

  lbs_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_PLL(ADDR_PLL), .ADDR_CLK(ADDR_CLK),
    .ADDR_MODE(ADDR_MODE), .ADDR_FRAME(ADDR_FRAME),
    .CFG_W(CFG_W), .LOCK_BIT(LOCK_BIT), .STREAM_BIT(STREAM_BIT)
  ) u_rmux (
    .rd_i     (reg_rd_i),
    .addr_i   (reg_addr_i),
    .pll_en_i (pll_en_q),
    .cfg_i    (cfg_q),
    .lock_i   (locked),
    .state_i  (state),
    .stream_i (stream_q),
    .rdata_o  (reg_rdata_o)
  );

  assign pll_en_o      = pll_en_q;
  assign clk_src_dsi_o = cfg_q[0];
  assign ref_idx_o     = cfg_q[CFG_W-1:1];
  assign train_req_o   = (state == LINK_TRAIN);
  assign link_state_o  = state;
  assign stream_en_o   = stream_q;
  assign lock_o        = locked;

endmodule

// File: rtl/lbs_checker.sv
`timescale 1ns/1ps
module lbs_checker #(
  parameter int         ADDR_W        = 8,
  parameter int         DATA_W        = 8,
  parameter logic [7:0] ADDR_MODE     = 8'h96,
  parameter int         TRAIN_TIMEOUT = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              pll_en_o,
  input logic              train_req_o,
  input logic [1:0]        link_state_o,
  input logic              stream_en_o,
  input logic              lock_o
);

  localparam int RUN_W = $clog2(TRAIN_TIMEOUT + 1) + 1;

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !train_req_o) run_q <= '0;
    else if (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_MODE) && reg_wdata_i == DATA_W'(8'h0A))
      run_q <= '0;
    else run_q <= run_q + 1'b1;
  end

  a_r7_stream_needs_normal: assert property (@(posedge clk) disable iff (rst)
    stream_en_o |-> link_state_o == 2'd2);

  a_r8_pll_off_when_link_off: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_en_o) |-> $past(link_state_o) == 2'd0);

  a_r5_train_starts_locked: assert property (@(posedge clk) disable iff (rst)
    $rose(train_req_o) |-> $past(lock_o));

  a_r4_normal_from_locked_train: assert property (@(posedge clk) disable iff (rst)
    (link_state_o == 2'd2 && $past(link_state_o) == 2'd1) |-> $past(lock_o));

  a_r9_stream_drop_on_lock_loss: assert property (@(posedge clk) disable iff (rst)
    ($past(link_state_o) == 2'd2 && $past(stream_en_o) && link_state_o == 2'd0)
      |-> !$past(lock_o));

  a_r6_train_bounded: assert property (@(posedge clk) disable iff (rst)
    train_req_o |-> run_q < RUN_W'(TRAIN_TIMEOUT));

endmodule

bind link_bringup_seq lbs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ADDR_MODE(ADDR_MODE), .TRAIN_TIMEOUT(TRAIN_TIMEOUT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .pll_en_o     (pll_en_o),
  .train_req_o  (train_req_o),
  .link_state_o (link_state_o),
  .stream_en_o  (stream_en_o),
  .lock_o       (lock_o)
);

// File: tb/tb_link_bringup_seq.sv
`timescale 1ns/1ps
module tb_link_bringup_seq;

  localparam int TO = 64;
  localparam logic [7:0] A_PLL = 8'h0D, A_CLK = 8'h0A, A_MODE = 8'h96, A_FRAME = 8'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic lock_in = 1'b0, done_in = 1'b0, pass_in = 1'b0;
  logic pll_en, clk_src, train_req, stream_en, lock_flag;
  logic [2:0] ref_idx;
  logic [1:0] link_state;

  always #2.5 clk = ~clk;

  link_bringup_seq #(.TRAIN_TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .pll_lock_i(lock_in), .train_done_i(done_in), .train_pass_i(pass_in),
    .pll_en_o(pll_en), .clk_src_dsi_o(clk_src), .ref_idx_o(ref_idx),
    .train_req_o(train_req), .link_state_o(link_state),
    .stream_en_o(stream_en), .lock_o(lock_flag)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  event sample_ev;

  // monitor: pops expected read values and compares
  initial begin
    forever begin
      rd_item_t it;
      @(sample_ev);
      it = sb_q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%02h expected=%02h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  // driver tasks: each starts just after a falling edge and ends at one
  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    #1 -> sample_ev;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk(8'(pll_en), 0, "R1 pll_en");
    chk(8'(link_state), 0, "R1 link_state");
    chk(8'(stream_en), 0, "R1 stream_en");
    chk(8'(train_req), 0, "R1 train_req");
    chk(8'(lock_flag), 0, "R1 lock");
    chk(8'(ref_idx), 0, "R1 ref_idx");
    rd(A_PLL, 8'h00, "R1 pll reg");
    rd(A_CLK, 8'h00, "R1 clk reg");
    rd(A_MODE, 8'h00, "R1 mode reg");
    rd(A_FRAME, 8'h00, "R1 frame reg");

    // R3 configuration fields
    wr(A_CLK, 8'hFF);
    rd(A_CLK, 8'h0F, "R3 upper bits ignored");
    chk(8'(clk_src), 1, "R3 src select");
    chk(8'(ref_idx), 7, "R3 ref index");
    wr(A_CLK, 8'h05);
    rd(A_CLK, 8'h05, "R3 second pattern");
    chk(8'(ref_idx), 2, "R3 ref index 2");

    // R5 training without lock
    wr(A_MODE, 8'h0A);
    rd(A_MODE, 8'h00, "R5 no lock fails");
    chk(8'(train_req), 0, "R5 no train_req");

    // R7 stream refused while off
    wr(A_FRAME, 8'h08);
    rd(A_FRAME, 8'h00, "R7 stream refused");
    chk(8'(stream_en), 0, "R7 stream_en off");

    // R2 PLL enable, R3 lock sync depth
    wr(A_PLL, 8'h01);
    chk(8'(pll_en), 1, "R2 pll_en");
    lock_in = 1'b1;
    tick(1);
    rd(A_CLK, 8'h05, "R3 lock after one stage");
    rd(A_CLK, 8'h85, "R3 lock after two stages");
    rd(A_PLL, 8'h01, "R2 pll readback");

    // R11 strobe low and unmapped
    reg_addr = A_PLL; reg_rd = 1'b0;
    #1 chk(reg_rdata, 8'h00, "R11 strobe low");
    tick(1);
    rd(8'h55, 8'h00, "R11 unmapped");

    // R10 other codes
    wr(A_MODE, 8'h33);
    rd(A_MODE, 8'h00, "R10 odd code ignored");

    // R4 failing training
    wr(A_MODE, 8'h0A);
    chk(8'(train_req), 1, "R4 train_req");
    chk(8'(link_state), 1, "R4 link training");
    rd(A_MODE, 8'h0A, "R4 training code");
    done_in = 1'b1; pass_in = 1'b0;
    tick(3);
    rd(A_MODE, 8'h00, "R4 fail result");
    done_in = 1'b0;
    tick(3);

    // R4 passing training, exact cycle
    wr(A_MODE, 8'h0A);
    done_in = 1'b1; pass_in = 1'b1;
    tick(2);
    rd(A_MODE, 8'h0A, "R4 before synced done");
    rd(A_MODE, 8'h01, "R4 pass result");
    chk(8'(link_state), 2, "R4 link normal");
    done_in = 1'b0; pass_in = 1'b0;
    tick(3);

    // R8 PLL off refused while linked
    wr(A_PLL, 8'h00);
    rd(A_PLL, 8'h01, "R8 pll stays on");

    // R7 stream on
    wr(A_FRAME, 8'h08);
    chk(8'(stream_en), 1, "R7 stream_en");
    wr(A_FRAME, 8'hFF);
    rd(A_FRAME, 8'h08, "R7 other bits zero");

    // R8 mode writes refused while streaming
    wr(A_MODE, 8'h00);
    rd(A_MODE, 8'h01, "R8 link off refused");
    wr(A_MODE, 8'h0A);
    rd(A_MODE, 8'h01, "R8 retrain refused");

    // R8 ordered shutdown
    wr(A_FRAME, 8'h00);
    chk(8'(stream_en), 0, "R8 stream cleared");
    wr(A_MODE, 8'h00);
    rd(A_MODE, 8'h00, "R8 link off");
    wr(A_PLL, 8'h00);
    chk(8'(pll_en), 0, "R8 pll off");
    rd(A_CLK, 8'h05, "R3 lock gated by pll");

    // R6 timeout boundary
    wr(A_PLL, 8'h01);
    wr(A_MODE, 8'h0A);
    tick(TO - 2);
    rd(A_MODE, 8'h0A, "R6 training near limit");
    rd(A_MODE, 8'h0A, "R6 last training cycle");
    rd(A_MODE, 8'h00, "R6 timeout result");

    // R9 lock loss while streaming
    wr(A_MODE, 8'h0A);
    done_in = 1'b1; pass_in = 1'b1;
    tick(4);
    chk(8'(link_state), 2, "R9 setup normal");
    done_in = 1'b0;
    wr(A_FRAME, 8'h08);
    chk(8'(stream_en), 1, "R9 setup stream");
    tick(3);
    lock_in = 1'b0;
    tick(2);
    chk(8'(link_state), 2, "R9 still normal in sync");
    chk(8'(stream_en), 1, "R9 still streaming in sync");
    tick(1);
    chk(8'(link_state), 0, "R9 link dropped");
    chk(8'(stream_en), 0, "R9 stream dropped same cycle");
    rd(A_FRAME, 8'h00, "R9 frame reg cleared");

    tick(2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule